// File: doc/BRIEF.md
# Light-Sleep Entry and Wake Controller

This controller decides when a processor core's clock is gated into a light sleep state and when it is released again. The core presents three strobes: a wait-for-interrupt request, a wait-for-event request and an exception-return strobe. It also presents three control bits: a deep-sleep select, a sleep-on-exit enable and a pending-to-event enable. Alongside these come the pending-interrupt lines with their enable mask and an external event input. The block drives a clock-gate enable, a sleeping flag and the current power mode, which is either low-power run or low-power sleep.

The wake condition depends on how sleep was entered. An interrupt-wait or sleep-on-exit entry is released only by an enabled pending interrupt. An event-wait entry is released by a wake event. When the pending-to-event enable is set, an event-wait entry is also released by any pending interrupt, masked or not. A one-bit event latch remembers events that arrive while the core runs, so that a later event-wait returns at once and does not sleep. The block leaves I/O pin state alone. Deeper sleep modes, regulator control and interrupt arbitration are handled elsewhere.

Top module: `lp_sleep_ctrl`

## Requirements
- R1: After reset `clk_en` is 1, `sleeping` is 0 and `pmode` is 0 (low-power run). In `pmode`, 0 means low-power run and 1 means low-power sleep.
- R2: A `wfi_req` pulse with `deep_sel`=0 and no enabled pending interrupt (no bit set in `irq_pend & irq_en`) enters sleep. From the next cycle `sleeping`=1, `pmode`=1 and `clk_en`=0, until a wake.
- R3: A `wfi_req` is ignored, and the core keeps running, when `deep_sel`=1 or when an enabled interrupt is pending.
- R4: A `wfe_req` that finds the event latch set, or an event arriving in the same cycle, does not enter sleep and clears the latch. A following `wfe_req` with no new event does enter sleep.
- R5: An `exc_ret` pulse enters sleep when `deep_sel`=0, `exit_sleep_en`=1 and no enabled interrupt is pending. With `exit_sleep_en`=0 it has no effect.
- R6: Sleep entered by `wfi_req` or `exc_ret` ends only on an enabled pending interrupt. A masked pending line or an `evt_in` pulse leaves the core asleep.
- R7: Sleep entered by `wfe_req` with `sev_on_pend`=0 ends only on a wake event. An enabled pending interrupt leaves it asleep.
- R8: Sleep entered by `wfe_req` with `sev_on_pend`=1 also ends on any pending interrupt, including one masked in `irq_en`.
- R9: `clk_en` returns to 1 combinationally in the cycle the wake condition is seen. `sleeping` and `pmode` return to 0 at the following clock edge.
- R10: The event latch is set by `evt_in` while running. When `sev_on_pend`=1 it is also set by a newly rising `irq_pend` bit, so that a later `wfe_req` does not sleep.
- R11: When a wait request and its wake condition arrive in the same cycle, the wake wins and sleep is not entered.
- R12: With `deep_sel`=1, none of the three entry strobes enters light sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wfi_req | input | 1 | Wait-for-interrupt request strobe |
| wfe_req | input | 1 | Wait-for-event request strobe |
| exc_ret | input | 1 | Return-from-handler strobe |
| deep_sel | input | 1 | Deep-sleep select; 1 blocks light sleep |
| exit_sleep_en | input | 1 | Sleep on return from handler enable |
| sev_on_pend | input | 1 | Pending interrupts act as events |
| irq_pend | input | N_IRQ | Pending interrupt lines |
| irq_en | input | N_IRQ | Interrupt enable mask |
| evt_in | input | 1 | Wake event input |
| clk_en | output | 1 | Core clock-gate enable (1 = clock runs) |
| sleeping | output | 1 | Core is in light sleep |
| pmode | output | 1 | Power mode: 0 low-power run, 1 low-power sleep |

## Verification
Entry is registered, so `sleeping`, `pmode` and the gated `clk_en` follow an entry strobe one clock later. A wake condition reopens `clk_en` in the same cycle, and `sleeping` drops one clock after that. The bench drives inputs on the falling edge and compares all three outputs one time unit later against a behavioural model. That model advances on each rising edge, so same-cycle and next-cycle results are each checked in the cycle they are due. Event-latch effects, which are not visible directly, are brought out through the next event-wait and whether it sleeps.

// File: rtl/lpsc_pkg.sv
package lpsc_pkg;

    typedef enum logic [1:0] {
        ENT_NONE = 2'd0,
        ENT_WFI  = 2'd1,
        ENT_WFE  = 2'd2,
        ENT_EXIT = 2'd3
    } entry_t;

    typedef enum logic {
        PM_LPRUN   = 1'b0,
        PM_LPSLEEP = 1'b1
    } pmode_t;

    typedef struct packed {
        logic en_pend;
        logic any_pend;
        logic evt_set;
    } wake_src_t;

    typedef struct packed {
        logic wfi;
        logic wfe;
        logic exc_ret;
        logic deep;
        logic exit_en;
        logic sev_pend;
    } req_t;

    function automatic logic wake_hit(entry_t kind, wake_src_t s, logic sev);
        logic hit;
        case (kind)
            ENT_WFI, ENT_EXIT: hit = s.en_pend;
            ENT_WFE:           hit = s.evt_set | (sev & s.any_pend);
            default:           hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/lpsc_pend_scan.sv
module lpsc_pend_scan
    import lpsc_pkg::*;
#(
    parameter int N_IRQ = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_IRQ-1:0] irq_pend,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic             evt_in,
    input  logic             sev_pend,
    output wake_src_t        src
);
    logic [N_IRQ-1:0] prev_q;
    logic [N_IRQ-1:0] rise;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= irq_pend;
    end

    for (genvar i = 0; i < N_IRQ; i++) begin : g_edge
        assign rise[i] = irq_pend[i] & ~prev_q[i];
    end

    always_comb begin
        src.en_pend  = |(irq_pend & irq_en);
        src.any_pend = |irq_pend;
        src.evt_set  = evt_in | (sev_pend & (|rise));
    end
endmodule

// File: rtl/lpsc_evt_latch.sv
module lpsc_evt_latch (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst)      q <= 1'b0;
        else if (clr) q <= 1'b0;
        else if (set) q <= 1'b1;
    end

    AST_EVT_LATCH_SET: assert property (@(posedge clk) disable iff (rst)
        (set && !clr) |=> q); // R10
endmodule

// File: rtl/lpsc_mode_fsm.sv
module lpsc_mode_fsm
    import lpsc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  req_t      req,
    input  wake_src_t src,
    input  logic      evt_lat,
    output logic      asleep,
    output logic      wake,
    output logic      lat_clr
);
    entry_t kind_q;
    logic   evt_pend;
    logic   wfi_go, wfe_try, wfe_go, exit_go, consume;

    always_comb begin
        wake     = asleep && wake_hit(kind_q, src, req.sev_pend);
        evt_pend = evt_lat | src.evt_set;
        wfi_go   = !asleep && req.wfi && !req.deep && !src.en_pend;
        wfe_try  = !asleep && !wfi_go && req.wfe && !req.deep;
        consume  = wfe_try && evt_pend;
        wfe_go   = wfe_try && !evt_pend;
        exit_go  = !asleep && !wfi_go && !wfe_try && req.exc_ret &&
                   req.exit_en && !req.deep && !src.en_pend;
        lat_clr  = consume || (wake && kind_q == ENT_WFE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            asleep <= 1'b0;
            kind_q <= ENT_NONE;
        end else if (wake) begin
            asleep <= 1'b0;
            kind_q <= ENT_NONE;
        end else if (wfi_go) begin
            asleep <= 1'b1;
            kind_q <= ENT_WFI;
        end else if (wfe_go) begin
            asleep <= 1'b1;
            kind_q <= ENT_WFE;
        end else if (exit_go) begin
            asleep <= 1'b1;
            kind_q <= ENT_EXIT;
        end
    end

    AST_WAKE_LEAVES_SLEEP: assert property (@(posedge clk) disable iff (rst)
        (asleep && wake) |=> !asleep); // R9
    AST_DEEP_BLOCKS_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (!asleep && req.deep) |=> !asleep); // R12
    AST_IRQ_WAIT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (asleep && (kind_q == ENT_WFI || kind_q == ENT_EXIT) && !src.en_pend) |=> asleep); // R6
    AST_EVT_WAIT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (asleep && kind_q == ENT_WFE && !src.evt_set && !(req.sev_pend && src.any_pend)) |=> asleep); // R7
endmodule

// File: rtl/lp_sleep_ctrl.sv
module lp_sleep_ctrl
    import lpsc_pkg::*;
#(
    parameter int N_IRQ = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wfi_req,
    input  logic             wfe_req,
    input  logic             exc_ret,
    input  logic             deep_sel,
    input  logic             exit_sleep_en,
    input  logic             sev_on_pend,
    input  logic [N_IRQ-1:0] irq_pend,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic             evt_in,
    output logic             clk_en,
    output logic             sleeping,
    output logic             pmode
);
    req_t      req;
    wake_src_t src;
    logic      evt_lat, asleep, wake, lat_clr;
    pmode_t    mode;

    always_comb begin
        req.wfi      = wfi_req;
        req.wfe      = wfe_req;
        req.exc_ret  = exc_ret;
        req.deep     = deep_sel;
        req.exit_en  = exit_sleep_en;
        req.sev_pend = sev_on_pend;
    end

    lpsc_pend_scan #(.N_IRQ(N_IRQ)) u_scan (
        .clk      (clk),
        .rst      (rst),
        .irq_pend (irq_pend),
        .irq_en   (irq_en),
        .evt_in   (evt_in),
        .sev_pend (sev_on_pend),
        .src      (src)
    );

    lpsc_evt_latch u_latch (
        .clk (clk),
        .rst (rst),
        .set (src.evt_set),
        .clr (lat_clr),
        .q   (evt_lat)
    );

    lpsc_mode_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .src     (src),
        .evt_lat (evt_lat),
        .asleep  (asleep),
        .wake    (wake),
        .lat_clr (lat_clr)
    );

    assign mode     = asleep ? PM_LPSLEEP : PM_LPRUN;
    assign pmode    = mode;
    assign sleeping = asleep;
    assign clk_en   = !asleep || wake;

    AST_PENDING_EVENT_NO_SLEEP: assert property (@(posedge clk) disable iff (rst)
        (!sleeping && evt_lat && wfe_req && !wfi_req && !deep_sel) |=> !sleeping); // R4
endmodule

// File: tb/tb_lp_sleep_ctrl.sv
module tb_lp_sleep_ctrl;
    localparam int PER = 10;
    localparam int NI  = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wfi_req = 0, wfe_req = 0, exc_ret = 0;
    logic deep_sel = 0, exit_sleep_en = 0, sev_on_pend = 0, evt_in = 0;
    logic [NI-1:0] irq_pend = '0, irq_en = '0;
    logic clk_en, sleeping, pmode;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // reference model state
    bit m_sleep = 0, m_lat = 0;
    int m_kind = 0; // 1 interrupt-wait, 2 event-wait, 3 exit
    logic [NI-1:0] m_prev = '0;

    always #(PER/2) clk = ~clk;

    lp_sleep_ctrl #(.N_IRQ(NI)) dut (
        .clk(clk), .rst(rst), .wfi_req(wfi_req), .wfe_req(wfe_req),
        .exc_ret(exc_ret), .deep_sel(deep_sel), .exit_sleep_en(exit_sleep_en),
        .sev_on_pend(sev_on_pend), .irq_pend(irq_pend), .irq_en(irq_en),
        .evt_in(evt_in), .clk_en(clk_en), .sleeping(sleeping), .pmode(pmode)
    );

    function automatic bit m_en_pend();
        return (irq_pend & irq_en) != 0;
    endfunction

    function automatic bit m_evt();
        return evt_in || (sev_on_pend && ((irq_pend & ~m_prev) != 0));
    endfunction

    function automatic bit m_wake();
        if (!m_sleep) return 0;
        if (m_kind == 1 || m_kind == 3) return m_en_pend();
        if (m_kind == 2) return m_evt() || (sev_on_pend && irq_pend != 0);
        return 0;
    endfunction

    always @(posedge clk) begin
        bit ev, w;
        ev = m_evt();
        w  = m_wake();
        if (rst) begin
            m_sleep = 0; m_lat = 0; m_kind = 0; m_prev = '0;
        end else begin
            if (m_sleep) begin
                if (w) begin
                    if (m_kind == 2) m_lat = 0; else m_lat = m_lat | ev;
                    m_sleep = 0; m_kind = 0;
                end else m_lat = m_lat | ev;
            end else if (!deep_sel && wfi_req && !m_en_pend()) begin
                m_sleep = 1; m_kind = 1; m_lat = m_lat | ev;
            end else if (!deep_sel && wfe_req) begin
                if (m_lat || ev) m_lat = 0;
                else begin m_sleep = 1; m_kind = 2; end
            end else if (!deep_sel && exc_ret && exit_sleep_en && !m_en_pend()) begin
                m_sleep = 1; m_kind = 3; m_lat = m_lat | ev;
            end else m_lat = m_lat | ev;
            m_prev = irq_pend;
        end
    end

    task automatic step(string tag);
        bit e_ce, e_sl;
        #1;
        e_sl = m_sleep;
        e_ce = !m_sleep || m_wake();
        n_chk++;
        if (clk_en !== e_ce || sleeping !== e_sl || pmode !== e_sl) begin
            n_fail++;
            $display("FAIL %s t=%0t actual clk_en=%b sleeping=%b pmode=%b expected clk_en=%b sleeping=%b pmode=%b",
                     tag, $time, clk_en, sleeping, pmode, e_ce, e_sl, e_sl);
        end
        @(negedge clk);
    endtask

    task automatic idle(string tag, int n);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    initial begin
        #(PER*5000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog (all requirements) actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        rst = 1; idle("R1 reset", 2);
        rst = 0; step("R1 after reset");

        // R2 entry by interrupt-wait; R6 masked line and event do not wake
        wfi_req = 1; step("R2 wfi pulse");
        wfi_req = 0; idle("R2 asleep", 2);
        irq_pend = 8'h01; idle("R6 masked pending", 2);
        evt_in = 1; step("R6 event ignored");
        evt_in = 0; step("R6 still asleep");
        irq_en = 8'h01; step("R9 same-cycle clk_en");
        step("R9 awake next cycle");
        irq_pend = '0; irq_en = '0; step("R9 idle");

        // R4 latch set by earlier event, consumed by first event-wait
        wfe_req = 1; step("R4 wfe consumes latch");
        wfe_req = 0; step("R4 still running");
        wfe_req = 1; step("R4 second wfe");
        wfe_req = 0; step("R4 asleep");
        // R7 enabled interrupt does not wake an event-wait
        irq_pend = 8'h04; irq_en = 8'h04; idle("R7 irq ignored", 3);
        evt_in = 1; step("R7 event wakes");
        evt_in = 0; step("R7 awake");
        irq_pend = '0; irq_en = '0; step("R7 idle");

        // R8 send-event-on-pending: masked interrupt wakes event-wait
        sev_on_pend = 1;
        wfe_req = 1; step("R8 wfe");
        wfe_req = 0; idle("R8 asleep", 2);
        irq_pend = 8'h10; step("R8 masked irq wakes");
        step("R8 awake");
        irq_pend = '0; step("R8 idle");

        // R10 rising pending line sets latch while running
        irq_pend = 8'h20; step("R10 new pending");
        irq_pend = '0; step("R10 drop");
        sev_on_pend = 0;
        wfe_req = 1; step("R10 wfe returns");
        wfe_req = 0; step("R10 not asleep");

        // R3 interrupt-wait blocked
        irq_pend = 8'h02; irq_en = 8'h02;
        wfi_req = 1; step("R3 enabled pending blocks");
        wfi_req = 0; step("R3 running");
        irq_pend = '0; irq_en = '0;
        deep_sel = 1; wfi_req = 1; step("R3 deep blocks");
        wfi_req = 0; step("R3 running");

        // R12 deep select blocks the other strobes
        wfe_req = 1; step("R12 wfe");
        wfe_req = 0; step("R12 running");
        exit_sleep_en = 1; exc_ret = 1; step("R12 exc_ret");
        exc_ret = 0; step("R12 running");
        deep_sel = 0;

        // R5 sleep on exit
        exc_ret = 1; step("R5 exit entry");
        exc_ret = 0; step("R5 asleep");
        evt_in = 1; step("R6 event ignored on exit sleep");
        evt_in = 0; irq_pend = 8'h80; step("R6 masked ignored");
        irq_en = 8'h80; step("R5 enabled irq wakes");
        step("R5 awake");
        exc_ret = 1; step("R5 pending blocks exit");
        exc_ret = 0; irq_pend = '0; irq_en = '0; step("R5 running");
        exit_sleep_en = 0; exc_ret = 1; step("R5 exit disabled");
        exc_ret = 0; step("R5 running");

        // R11 wait and wake condition in the same cycle
        wfe_req = 1; evt_in = 1; step("R11 wfe with event");
        wfe_req = 0; evt_in = 0; step("R11 not asleep");
        irq_pend = 8'h08; irq_en = 8'h08; wfi_req = 1; step("R11 wfi with irq");
        wfi_req = 0; step("R11 not asleep");
        irq_pend = '0; irq_en = '0; idle("R1 idle", 2);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule